// File: doc/BRIEF.md
# Timer Channel Capture-Compare Unit

This block is one channel of a general-purpose timer. It watches a shared free-running counter, which it does not own, and keeps its own channel value register. Software programs a status/control byte through a simple read/write strobe interface. The byte selects one of three jobs for the channel: input capture, output compare or edge-aligned PWM.

In every mode the channel raises a sticky event flag, and an interrupt request that the flag drives. Software clears the flag in two steps. It first reads the control byte while the flag is set, which arms the clear, and then writes a zero to the flag bit. Any channel event that lands before the clearing write takes effect cancels the armed state, so an event is never lost. In PWM mode a duty of 0% or 100% produces no compare events.

Top module: `tmr_ccu_chan`

## Requirements
- R1: After reset the control byte reads 0x00, the value register reads 0, and `irq_o` and `ch_o` are 0.
- R2: `reg_sel_i` = 0 addresses the control byte and `reg_sel_i` = 1 addresses the value register. Control bit 6 is the interrupt enable, bit 5 is mode B, bit 4 is mode A, bit 3 is level B and bit 2 is level A. All of these read back as written, and bits 1:0 always read 0.
- R3: With both mode bits 0, the levels {B,A} select the capture edge: 01 rising, 10 falling, 11 both, 00 off. `pin_i` passes through a two-flop synchronizer. The counter value is latched into the value register, and the flag is set, at the third rising clock edge after `pin_i` changes.
- R4: With mode {B,A} = 01, `cnt_i` equal to the value register sets the flag at the next clock edge. At that same edge `ch_o` toggles for levels 01, clears for 10 and sets for 11.
- R5: With mode B = 1 (edge-aligned PWM), `ch_o` is registered from the active state. The channel is active while `cnt_i` is below the value register. Level B = 1 makes the output high-true and level B = 0 makes it low-true. A counter match sets the flag.
- R6: In PWM mode a value of 0 keeps the channel inactive and a value above `mod_i` keeps it active. In both cases the flag is never set.
- R7: `irq_o` is 1 exactly when the flag is set and the interrupt enable is 1.
- R8: A control write with bit 7 = 0 clears the flag only when a control read was made while the flag was set, and no event has occurred since that read. Without such a read the flag stays set.
- R9: A control write with bit 7 = 1 leaves the flag and any armed clear unchanged, while bits 6:2 are still written.
- R10: An event after the arming read cancels the clear. An event in the same cycle as the clearing write also cancels it. In both cases the flag stays set.
- R11: A capture and a bus write to the value register in the same cycle leave the captured counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CW | Shared counter value |
| mod_i | input | CW | Counter modulo (period end) |
| pin_i | input | 1 | Asynchronous capture input |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_sel_i | input | 1 | 0 control byte, 1 value register |
| wdata_i | input | CW | Write data |
| rdata_o | output | CW | Read data (combinational) |
| ch_o | output | 1 | Compare/PWM channel output |
| irq_o | output | 1 | Interrupt request |

## Verification
The case that matters is a new channel event arriving in the same clock cycle as the clearing write. The flag logic has to resolve set against clear within that one cycle. The bench arms the clear with a read, then holds the counter equal to the value register for exactly the cycle that carries the write strobe. It judges the outcome by a still-asserted interrupt and a flag that reads back set. It then confirms that a fresh read-and-write pair clears the flag, which shows the cancelled sequence left no stale armed state. A capture that coincides with a bus write to the value register is provoked the same way, by timing the write onto the latch edge.

// File: rtl/tmr_ccu_pkg.sv
package tmr_ccu_pkg;
  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_VAL  = 1'b1;

  typedef struct packed {
    logic ie;
    logic msb;
    logic msa;
    logic elsb;
    logic elsa;
  } ctrl_t;
endpackage

// File: rtl/tmr_ccu_sync_edge.sv
module tmr_ccu_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= pin_i;
        else sync_q[i] <= sync_q[(i > 0) ? i-1 : 0];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/tmr_ccu_flag.sv
module tmr_ccu_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic event_i,
  input  logic arm_i,
  input  logic clr_i,
  output logic flag_o,
  output logic armed_o
);
  logic flag_q, armed_q;

  // new event wins over clear and disarms any pending sequence
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (event_i) begin
      flag_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (clr_i && armed_q) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (arm_i && flag_q) begin
      armed_q <= 1'b1;
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/tmr_ccu_out.sv
module tmr_ccu_out #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pwm_i,
  input  logic          oc_i,
  input  logic          elsb_i,
  input  logic          elsa_i,
  input  logic          match_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] val_i,
  input  logic [CW-1:0] mod_i,
  output logic          ch_o
);
  logic ch_q, ch_d, act;

  // val 0 never active, val above modulo always active
  assign act = (val_i > mod_i) | (cnt_i < val_i);

  always_comb begin
    ch_d = ch_q;
    if (pwm_i) begin
      ch_d = elsb_i ? act : ~act;
    end else if (oc_i && match_i) begin
      unique case ({elsb_i, elsa_i})
        2'b01:   ch_d = ~ch_q;
        2'b10:   ch_d = 1'b0;
        2'b11:   ch_d = 1'b1;
        default: ch_d = ch_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ch_q <= 1'b0;
    else ch_q <= ch_d;
  end

  assign ch_o = ch_q;
endmodule

// File: rtl/tmr_ccu_chan.sv
module tmr_ccu_chan
  import tmr_ccu_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] mod_i,
  input  logic          pin_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic          reg_sel_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] rdata_o,
  output logic          ch_o,
  output logic          irq_o
);
  localparam int PADW = CW - 8;

  ctrl_t         ctrl_q;
  logic [CW-1:0] val_q;
  logic          rise_w, fall_w;
  logic          flag_w, armed_w, event_w;
  logic          cap_mode, oc_mode, pwm_mode_w, elsb_w;
  logic          match_w, pwm_quiet, cap_hit, cmp_hit;
  logic          wr_ctrl, wr_val;
  logic [CW-1:0] val_w;

  assign cap_mode   = ~ctrl_q.msb & ~ctrl_q.msa;
  assign oc_mode    = ~ctrl_q.msb &  ctrl_q.msa;
  assign pwm_mode_w =  ctrl_q.msb;
  assign elsb_w     =  ctrl_q.elsb;
  assign val_w      =  val_q;

  assign wr_ctrl = reg_wr_i & (reg_sel_i == SEL_CTRL);
  assign wr_val  = reg_wr_i & (reg_sel_i == SEL_VAL);

  tmr_ccu_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  assign cap_hit   = cap_mode & ((ctrl_q.elsa & rise_w) | (ctrl_q.elsb & fall_w));
  assign match_w   = (cnt_i == val_q);
  assign pwm_quiet = (val_q == '0) | (val_q > mod_i);
  assign cmp_hit   = ~cap_mode & match_w & ~(pwm_mode_w & pwm_quiet);
  assign event_w   = cap_hit | cmp_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[6:2]);
  end

  // capture beats a same-cycle bus write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= '0;
    else if (cap_hit) val_q <= cnt_i;
    else if (wr_val) val_q <= wdata_i;
  end

  tmr_ccu_flag i_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .event_i (event_w),
    .arm_i   (reg_rd_i & (reg_sel_i == SEL_CTRL)),
    .clr_i   (wr_ctrl & ~wdata_i[7]),
    .flag_o  (flag_w),
    .armed_o (armed_w)
  );

  tmr_ccu_out #(.CW(CW)) i_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pwm_i   (pwm_mode_w),
    .oc_i    (oc_mode),
    .elsb_i  (ctrl_q.elsb),
    .elsa_i  (ctrl_q.elsa),
    .match_i (match_w),
    .cnt_i   (cnt_i),
    .val_i   (val_q),
    .mod_i   (mod_i),
    .ch_o    (ch_o)
  );

  assign rdata_o = (reg_sel_i == SEL_CTRL) ?
                   {{PADW{1'b0}}, flag_w, ctrl_q, 2'b00} : val_q;
  assign irq_o   = flag_w & ctrl_q.ie;
endmodule

// File: rtl/tmr_ccu_chk.sv
module tmr_ccu_chk #(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          event_w,
  input logic          flag_w,
  input logic          armed_w,
  input logic          reg_wr_i,
  input logic          reg_sel_i,
  input logic [CW-1:0] wdata_i,
  input logic [CW-1:0] rdata_o,
  input logic          irq_o,
  input logic          ch_o,
  input logic          pwm_mode_w,
  input logic          elsb_w,
  input logic [CW-1:0] val_w,
  input logic [CW-1:0] mod_i
);
  a_r10_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_w |=> flag_w);

  a_r8_unarmed_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_w && !armed_w) |=> flag_w);

  a_r9_one_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_w && reg_wr_i && !reg_sel_i && wdata_i[7]) |=> flag_w);

  a_r7_flag_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_w) |-> $past(event_w));

  a_r7_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_w);

  a_r2_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_sel_i |-> (rdata_o[1:0] == 2'b00));

  a_r6_full_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_mode_w && (val_w > mod_i)) |=> (ch_o == $past(elsb_w)));
endmodule

bind tmr_ccu_chan tmr_ccu_chk #(.CW(CW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .event_w    (event_w),
  .flag_w     (flag_w),
  .armed_w    (armed_w),
  .reg_wr_i   (reg_wr_i),
  .reg_sel_i  (reg_sel_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .irq_o      (irq_o),
  .ch_o       (ch_o),
  .pwm_mode_w (pwm_mode_w),
  .elsb_w     (elsb_w),
  .val_w      (val_w),
  .mod_i      (mod_i)
);

// File: tb/test_tmr_ccu_chan.sv
module test_tmr_ccu_chan;
  localparam int CW = 16;
  localparam logic [CW-1:0] PARK = 16'd1000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cnt = PARK;
  logic [CW-1:0] modv = 16'd2000;
  logic          pin = 1'b0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
  logic [CW-1:0] wdata = '0;
  logic [CW-1:0] rdata;
  logic          ch, irq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  tmr_ccu_chan #(.CW(CW)) i_tmr_ccu_chan (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .mod_i(modv), .pin_i(pin),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_sel_i(reg_sel),
    .wdata_i(wdata), .rdata_o(rdata), .ch_o(ch), .irq_o(irq)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [CW-1:0] d);
    reg_sel = sel; wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [CW-1:0] d);
    reg_sel = sel; reg_rd = 1'b1;
    #1 d = rdata;
    tick();
    reg_rd = 1'b0;
  endtask

  // peek without arming: select only, no strobe
  task automatic peek(input logic sel, output logic [CW-1:0] d);
    reg_sel = sel;
    #1 d = rdata;
  endtask

  task automatic clear_flag(input logic [7:0] cfg);
    logic [CW-1:0] d;
    rd(1'b0, d);
    wr(1'b0, {8'h00, cfg & 8'h7F});
  endtask

  task automatic match_pulse(input logic [CW-1:0] v);
    cnt = v; tick(); cnt = PARK;
  endtask

  task automatic t_reset();
    logic [CW-1:0] d;
    peek(1'b0, d); chk("R1 ctrl", d, 16'h0000);
    peek(1'b1, d); chk("R1 value", d, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 ch", {15'd0, ch}, 16'd0);
  endtask

  task automatic t_ctrl();
    logic [CW-1:0] d;
    wr(1'b0, 16'h00FF);
    peek(1'b0, d); chk("R2 layout, R9 flag not set by write", d, 16'h007C);
    wr(1'b0, 16'h0054);
    peek(1'b0, d); chk("R2 pattern 0x54", d, 16'h0054);
    wr(1'b0, 16'h0000);
  endtask

  task automatic t_capture();
    logic [CW-1:0] d;
    wr(1'b0, 16'h0084);               // rising
    cnt = 16'h0123; pin = 1'b1;
    tick(); tick();
    peek(1'b1, d); chk("R3 not yet latched", d, 16'h0000);
    tick();
    peek(1'b1, d); chk("R3 rising latch", d, 16'h0123);
    peek(1'b0, d); chk("R3 flag rising", d, 16'h0084);
    clear_flag(8'h08);                // falling only
    cnt = 16'h0456; pin = 1'b0;
    tick(); tick(); tick();
    peek(1'b1, d); chk("R3 falling latch", d, 16'h0456);
    clear_flag(8'h08);
    cnt = 16'h0789; pin = 1'b1;
    tick(); tick(); tick(); tick();
    peek(1'b1, d); chk("R3 rising ignored in falling mode", d, 16'h0456);
    peek(1'b0, d); chk("R3 no flag wrong edge", d, 16'h0008);
    wr(1'b0, 16'h008C);               // both
    cnt = 16'h0ABC; pin = 1'b0;
    tick(); tick(); tick();
    peek(1'b1, d); chk("R3 both edges", d, 16'h0ABC);
    clear_flag(8'h0C);
    // R11: write lands on latch edge
    cnt = 16'h0DEF; pin = 1'b1;
    tick(); tick();
    wr(1'b1, 16'hAAAA);
    peek(1'b1, d); chk("R11 capture beats write", d, 16'h0DEF);
    clear_flag(8'h00);
    cnt = PARK;
  endtask

  task automatic t_compare();
    logic [CW-1:0] d;
    wr(1'b1, 16'd500);
    wr(1'b0, 16'h0094);               // OC toggle, ie off
    chk("R4 ch before", {15'd0, ch}, 16'd0);
    match_pulse(16'd500);
    chk("R4 toggle high", {15'd0, ch}, 16'd1);
    peek(1'b0, d); chk("R4 flag set", d, 16'h0094);
    chk("R7 irq gated off", {15'd0, irq}, 16'd0);
    wr(1'b0, 16'h00D4);
    chk("R7 irq on", {15'd0, irq}, 16'd1);
    clear_flag(8'h54);
    chk("R8 cleared irq", {15'd0, irq}, 16'd0);
    match_pulse(16'd500);
    chk("R4 toggle low", {15'd0, ch}, 16'd0);
    wr(1'b0, 16'h00DC);
    match_pulse(16'd500);
    chk("R4 set", {15'd0, ch}, 16'd1);
    wr(1'b0, 16'h00D8);
    match_pulse(16'd500);
    chk("R4 clear", {15'd0, ch}, 16'd0);
    wr(1'b0, 16'h00D4);
  endtask

  task automatic t_clear_seq();
    logic [CW-1:0] d;
    // flag set, unarmed after last event
    wr(1'b0, 16'h0054);
    chk("R8 unarmed write keeps flag", {15'd0, irq}, 16'd1);
    rd(1'b0, d);
    wr(1'b0, 16'h00D4);
    chk("R9 write one keeps flag", {15'd0, irq}, 16'd1);
    wr(1'b0, 16'h0054);
    chk("R8 armed write clears", {15'd0, irq}, 16'd0);
    match_pulse(16'd500);
    rd(1'b0, d);
    match_pulse(16'd500);
    wr(1'b0, 16'h0054);
    chk("R10 event after read cancels", {15'd0, irq}, 16'd1);
    rd(1'b0, d);
    cnt = 16'd500;
    wr(1'b0, 16'h0054);
    cnt = PARK;
    chk("R10 same-cycle event keeps irq", {15'd0, irq}, 16'd1);
    peek(1'b0, d); chk("R10 same-cycle flag", d, 16'h00D4);
    clear_flag(8'h54);
    chk("R10 later clear works", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_pwm();
    logic [CW-1:0] d;
    modv = 16'd9; cnt = 16'd9;
    wr(1'b1, 16'd4);
    wr(1'b0, 16'h00A8);               // PWM high-true, ie off
    for (int c = 0; c <= 9; c++) begin
      cnt = c[CW-1:0]; tick();
      chk("R5 high-true", {15'd0, ch}, (c < 4) ? 16'd1 : 16'd0);
    end
    peek(1'b0, d); chk("R5 match flag", d, 16'h00A8);
    wr(1'b0, 16'h00A0);
    cnt = 16'd2; tick(); chk("R5 low-true active", {15'd0, ch}, 16'd0);
    cnt = 16'd7; tick(); chk("R5 low-true idle", {15'd0, ch}, 16'd1);
    cnt = 16'd9;
    clear_flag(8'h68);                // ie on, high-true
    wr(1'b1, 16'd0);
    for (int c = 0; c <= 9; c++) begin
      cnt = c[CW-1:0]; tick();
      chk("R6 zero duty", {15'd0, ch}, 16'd0);
    end
    chk("R6 zero duty no irq", {15'd0, irq}, 16'd0);
    wr(1'b1, 16'd10);
    for (int c = 0; c <= 9; c++) begin
      cnt = c[CW-1:0]; tick();
      chk("R6 full duty", {15'd0, ch}, 16'd1);
    end
    chk("R6 full duty no irq", {15'd0, irq}, 16'd0);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_ctrl();
    t_capture();
    t_compare();
    t_clear_seq();
    t_pwm();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule